// File: doc/BRIEF.md
# Received Call Record Formatter

This block sits between a paging codeword decoder and a message byte buffer. It turns each decoded codeword into a 3-byte record and writes the bytes, one per clock, into a circular buffer that a host drains later. A call is written as one header record, then zero or more message records, then one terminator record. An alert-only call has just the header and the terminator. When a second matching address arrives while a call is still open, its header closes the first call in place of a terminator. In continuous decoding mode every codeword is written as a message record and the call structure is ignored.

The block keeps the write pointer. It compares that pointer against a read pointer supplied from the host side to find the fill level and the full condition. It raises a transfer request at batch sync slots, when a call closes, and as soon as the buffer fills.

Top module: `call_record_fmt`

## Requirements
- R1: After reset, `buf_we` and `xfer_irq` are low and the first record byte goes to address 0.
- R2: A header record (a codeword with `cw_is_hdr` high, continuous mode off) is byte A = {0, sync_id[2:0], hit_user[2:0], DF}, then byte B = {0, sync_id[2:0], hit_user[2:0], 0}, then byte C = {0, 0, hit_fn[0], hit_fn[1], E[2:0], 0}. E is `cw_err`, coded as: 000 clean, 001 parity only, 010 one bit, 011 one bit plus parity, 101 burst plus parity, 110 two bits, 111 uncorrectable.
- R3: A message record is byte A = cw_data[30:23], byte B = cw_data[22:15], byte C = {cw_data[14:11], E[2:0], cw_data[31]}. Here cw_data[31] is the codeword flag (1 means message).
- R4: While a call is open, a codeword is stored as a message if its flag is 1, or if its flag is 0 and its error code is 100 or higher. A flag-0 codeword with error code 011 or lower is not stored. With no call open and continuous mode off, a codeword that does not match a header is not stored.
- R5: `term_evt` while a call is open writes a terminator. Byte A = {term_cause, sync_id, 000, DF}, byte B = {term_cause, sync_id, 000, 0}, byte C = {0000, 0, cw_err[1:0], 0}, so E3 is always 0.
- R6: A header that arrives while a call is open takes the place of the terminator and opens the new call. Its E3 is forced to 0.
- R7: DF is 1 when `data_fail` is high or `sync_id` is 0 (no programmed sync word matched). 7 denotes the standard sync word.
- R8: With `cont_mode` high, every valid codeword is written as a message record, header matches included, with cw_data[31] in the flag position. `term_evt` has no effect in this mode.
- R9: Record bytes are written A, B, C on consecutive cycles to consecutive addresses. The address wraps modulo DEPTH.
- R10: While fill (write pointer minus `rd_ptr`) equals DEPTH, no byte is written and the skipped bytes are lost.
- R11: `xfer_irq` is set by a sync slot with a non-empty buffer, by the last byte of a closing record, or by the full condition. It clears once fill returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Corrected codeword strobe, one cycle |
| cw_data | input | 32 | Corrected codeword, bit 31 is the flag |
| cw_err | input | 3 | Error type of the codeword |
| cw_is_hdr | input | 1 | Codeword matched an enabled user address |
| hit_user | input | 3 | Index of the matched user address |
| hit_fn | input | 2 | Function bits of the matched address |
| sync_id | input | 3 | Identifier of the current batch sync word |
| data_fail | input | 1 | Data-fail state flag |
| term_evt | input | 1 | Call termination strobe |
| term_cause | input | 1 | Termination cause bit |
| cont_mode | input | 1 | Continuous decoding mode |
| sync_slot | input | 1 | Batch sync position strobe |
| rd_ptr | input | PW | Host read pointer, one wrap bit above the address |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | AW | Buffer write address |
| buf_wdata | output | 8 | Buffer write byte |
| xfer_irq | output | 1 | Transfer request to the host |

## Verification
The bench builds the block with DEPTH = 16, so the pointer is 5 bits and the address is 4 bits. Under that setting a few records carry the write address past the wrap point. Six back-to-back continuous records fill the buffer exactly partway through a record, which shows the dropped tail bytes and the full-driven request. The default depth of 128 holds two batches of records and would need far longer stimulus to reach those corners.

// File: rtl/crf_pkg.sv
package crf_pkg;
  typedef enum logic [1:0] {
    REC_HDR  = 2'd0,
    REC_MSG  = 2'd1,
    REC_TERM = 2'd2
  } rec_kind_e;

  localparam logic [2:0] SYNC_NONE     = 3'd0;
  localparam logic [2:0] ERR_MULTI_MIN = 3'b100;

  function automatic logic [23:0] pack_msg(input logic [31:0] cw,
                                           input logic [2:0]  err);
    return {cw[30:23], cw[22:15], cw[14:11], err, cw[31]};
  endfunction
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/crf_classify.sv
module crf_classify
  import crf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cw_valid,
  input  logic [31:0] cw_data,
  input  logic [2:0]  cw_err,
  input  logic        cw_is_hdr,
  input  logic [2:0]  hit_user,
  input  logic [1:0]  hit_fn,
  input  logic [2:0]  sync_id,
  input  logic        data_fail,
  input  logic        term_evt,
  input  logic        term_cause,
  input  logic        cont_mode,
  output logic        rec_valid,
  output rec_kind_e   rec_kind,
  output logic [23:0] rec_data,
  output logic        rec_close
);
  logic call_q, call_d;
  logic df, heavy, hdr_ev, msg_ev, term_ev, concat;
  logic [2:0] hdr_err;

  always_comb begin
    df      = data_fail | (sync_id == SYNC_NONE);
    heavy   = (cw_err >= ERR_MULTI_MIN);
    hdr_ev  = cw_valid & cw_is_hdr & ~cont_mode;
    msg_ev  = cw_valid & (cont_mode |
              (call_q & ~cw_is_hdr & (cw_data[31] | heavy)));
    term_ev = term_evt & call_q & ~cont_mode & ~hdr_ev & ~msg_ev;
    concat  = hdr_ev & call_q;
    hdr_err = concat ? {1'b0, cw_err[1:0]} : cw_err;

    rec_valid = hdr_ev | msg_ev | term_ev;
    rec_close = concat | term_ev;
    rec_kind  = REC_MSG;
    rec_data  = pack_msg(cw_data, cw_err);
    if (hdr_ev) begin
      rec_kind = REC_HDR;
      rec_data = {1'b0, sync_id, hit_user, df,
                  1'b0, sync_id, hit_user, 1'b0,
                  2'b00, hit_fn[0], hit_fn[1], hdr_err, 1'b0};
    end else if (term_ev) begin
      rec_kind = REC_TERM;
      rec_data = {term_cause, sync_id, 3'b000, df,
                  term_cause, sync_id, 3'b000, 1'b0,
                  4'b0000, 1'b0, cw_err[1:0], 1'b0};
    end
  end

  always_comb begin
    call_d = call_q;
    if (cont_mode)    call_d = 1'b0;
    else if (hdr_ev)  call_d = 1'b1;
    else if (term_ev) call_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) call_q <= 1'b0;
    else        call_q <= call_d;
  end

  AST_HDR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_is_hdr && !cont_mode) |=> call_q); // R6
  AST_CONT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    cont_mode |=> !call_q); // R8
endmodule

// File: rtl/crf_writer.sv
module crf_writer
  import crf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  rec_kind_e     rec_kind,
  input  logic [23:0]   rec_data,
  input  logic          rec_close,
  input  logic [PW-1:0] rd_ptr,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          close_done,
  output logic          full,
  output logic [PW-1:0] fill
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic          busy_q, busy_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [23:0]   data_q, data_d;
  rec_kind_e     kind_q, kind_d;
  logic          close_q, close_d;
  logic [PW-1:0] wr_q, wr_d;
  logic          last, accept;

  always_comb begin
    fill   = wr_q - rd_ptr;
    full   = (fill == DEPTH_P);
    last   = busy_q & (cnt_q == 2'd2);
    accept = rec_valid & (~busy_q | last);
    buf_we = busy_q & ~full;
    buf_addr = wr_q[AW-1:0];
    case (cnt_q)
      2'd0:    buf_wdata = data_q[23:16];
      2'd1:    buf_wdata = data_q[15:8];
      default: buf_wdata = data_q[7:0];
    endcase
    close_done = last & close_q;
  end

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    kind_d  = kind_q;
    close_d = close_q;
    wr_d    = wr_q + {{(PW-1){1'b0}}, buf_we};
    if (accept) begin
      busy_d  = 1'b1;
      cnt_d   = 2'd0;
      data_d  = rec_data;
      kind_d  = rec_kind;
      close_d = rec_close;
    end else if (last) begin
      busy_d  = 1'b0;
    end else if (busy_q) begin
      cnt_d   = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= 2'd0;
      data_q  <= 24'd0;
      kind_q  <= REC_MSG;
      close_q <= 1'b0;
      wr_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      kind_q  <= kind_d;
      close_q <= close_d;
      wr_q    <= wr_d;
    end
  end

  AST_REC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (!busy_q || last)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (buf_addr == $past(buf_addr) + AW'(1))); // R9
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_P); // R10
  AST_TERM_E3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && kind_q == REC_TERM && cnt_q == 2'd2) |-> !buf_wdata[3]); // R5
endmodule

// File: rtl/crf_xfer_req.sv
module crf_xfer_req #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_slot,
  input  logic          close_done,
  input  logic          full,
  input  logic [PW-1:0] fill,
  output logic          xfer_irq
);
  logic irq_q, irq_d, set, empty;

  always_comb begin
    empty = (fill == '0);
    set   = (sync_slot & ~empty) | close_done | full;
    irq_d = irq_q;
    if (set)        irq_d = 1'b1;
    else if (empty) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign xfer_irq = irq_q;

  AST_IRQ_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> xfer_irq); // R11
  AST_IRQ_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_done |=> xfer_irq); // R11
endmodule

// File: rtl/call_record_fmt.sv
module call_record_fmt
  import crf_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_valid,
  input  logic [31:0]   cw_data,
  input  logic [2:0]    cw_err,
  input  logic          cw_is_hdr,
  input  logic [2:0]    hit_user,
  input  logic [1:0]    hit_fn,
  input  logic [2:0]    sync_id,
  input  logic          data_fail,
  input  logic          term_evt,
  input  logic          term_cause,
  input  logic          cont_mode,
  input  logic          sync_slot,
  input  logic [PW-1:0] rd_ptr,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic          xfer_irq
);
  logic          rst_sync_n;
  logic          rec_valid, rec_close, close_done, full;
  rec_kind_e     rec_kind;
  logic [23:0]   rec_data;
  logic [PW-1:0] fill;

  crf_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  crf_classify u_cls (
    .clk(clk), .rst_n(rst_sync_n),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_err(cw_err),
    .cw_is_hdr(cw_is_hdr), .hit_user(hit_user), .hit_fn(hit_fn),
    .sync_id(sync_id), .data_fail(data_fail),
    .term_evt(term_evt), .term_cause(term_cause), .cont_mode(cont_mode),
    .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_data(rec_data),
    .rec_close(rec_close)
  );

  crf_writer #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(clk), .rst_n(rst_sync_n),
    .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_data(rec_data),
    .rec_close(rec_close), .rd_ptr(rd_ptr),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .close_done(close_done), .full(full), .fill(fill)
  );

  crf_xfer_req #(.PW(PW)) u_xf (
    .clk(clk), .rst_n(rst_sync_n),
    .sync_slot(sync_slot), .close_done(close_done), .full(full),
    .fill(fill), .xfer_irq(xfer_irq)
  );
endmodule

// File: tb/sim_call_record_fmt.sv
`timescale 1ns/1ps
module sim_call_record_fmt;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cw_valid, cw_is_hdr, data_fail, term_evt, term_cause, cont_mode, sync_slot;
  logic [31:0] cw_data;
  logic [2:0] cw_err, hit_user, sync_id;
  logic [1:0] hit_fn;
  logic [PW-1:0] rd_ptr;
  logic buf_we, xfer_irq;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;

  int checks = 0;
  int fails = 0;
  int exp_wr = 0;
  logic [15:0] q[$];
  string q_tag[$];

  always #2 clk = ~clk;

  call_record_fmt #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_data(cw_data),
    .cw_err(cw_err), .cw_is_hdr(cw_is_hdr), .hit_user(hit_user),
    .hit_fn(hit_fn), .sync_id(sync_id), .data_fail(data_fail),
    .term_evt(term_evt), .term_cause(term_cause), .cont_mode(cont_mode),
    .sync_slot(sync_slot), .rd_ptr(rd_ptr), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .xfer_irq(xfer_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Push one expected byte; model of R9/R10 pointer and full rule.
  task automatic push_byte(input logic [7:0] b, input string tag);
    int fillv = (exp_wr - int'(rd_ptr)) & (2*DEPTH-1);
    if (fillv < DEPTH) begin
      q.push_back({4'(exp_wr % DEPTH), 4'd0, b});
      q_tag.push_back(tag);
      exp_wr = (exp_wr + 1) % (2*DEPTH);
    end
  endtask

  task automatic push_rec(input logic [23:0] r, input string tag);
    push_byte(r[23:16], tag);
    push_byte(r[15:8], tag);
    push_byte(r[7:0], tag);
  endtask

  task automatic idle_inputs();
    cw_valid = 0; cw_is_hdr = 0; term_evt = 0; sync_slot = 0;
  endtask

  task automatic send_cw(input logic [31:0] d, input logic [2:0] e, input bit hdr,
                         input logic [2:0] u, input logic [1:0] f);
    @(negedge clk);
    cw_valid = 1; cw_data = d; cw_err = e; cw_is_hdr = hdr; hit_user = u; hit_fn = f;
    @(negedge clk);
    idle_inputs();
    repeat (6) @(negedge clk);
  endtask

  task automatic send_term(input bit cause, input logic [2:0] e);
    @(negedge clk);
    term_evt = 1; term_cause = cause; cw_err = e;
    @(negedge clk);
    idle_inputs();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [23:0] msg_rec(input logic [31:0] d, input logic [2:0] e);
    return {d[30:23], d[22:15], d[14:11], e, d[31]};
  endfunction

  // Monitor: pop and compare every byte the design writes.
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (q.size() == 0) begin
        check(0, "R4/R8/R10 unexpected write", {buf_addr, buf_wdata}, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = q.pop_front();
        t = q_tag.pop_front();
        check(buf_addr == e[15:12] && buf_wdata == e[7:0], t,
              {buf_addr, 4'd0, buf_wdata}, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    check(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs();
    cw_data = 0; cw_err = 0; hit_user = 0; hit_fn = 0; sync_id = 3'd7;
    data_fail = 0; term_cause = 0; cont_mode = 0; rd_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(buf_we == 0 && xfer_irq == 0, "R1 reset outputs", {buf_we, xfer_irq}, 0);

    // R2 R7 header, sync 3, user 5, fn 10, err 010 -> 3A 3A 14 at addr 0..2 (R1)
    sync_id = 3'd3;
    push_rec(24'h3A3A14, "R2 header");
    send_cw(32'h1234_5678, 3'b010, 1, 3'd5, 2'b10);
    check(xfer_irq == 0, "R11 no request for open call", xfer_irq, 0);

    // R3 message flag 1
    push_rec(msg_rec(32'hABCD_1234, 3'b001), "R3 message");
    send_cw(32'hABCD_1234, 3'b001, 0, 0, 0);

    // R4 flag 0 with two-bit error is stored
    push_rec(msg_rec(32'h5A5A_F00F, 3'b110), "R4 heavy flag0 stored");
    send_cw(32'h5A5A_F00F, 3'b110, 0, 0, 0);

    // R4 flag 0 clean, not matching: not stored (monitor flags any write)
    send_cw(32'h0F0F_0F0F, 3'b000, 0, 0, 0);

    // R6 R7 concatenated header: sync 0 -> DF, err 111 -> 011
    sync_id = 3'd0;
    push_rec(24'h030236, "R6 concat header");
    send_cw(32'h0000_0001, 3'b111, 1, 3'd1, 2'b11);
    check(xfer_irq == 1, "R11 request after call close", xfer_irq, 1);
    rd_ptr = 5'd12;
    @(negedge clk); @(negedge clk);
    check(xfer_irq == 0, "R11 request clears when drained", xfer_irq, 0);

    // R5 R7 terminator: cause 1, sync 7, data_fail, err 101 -> E 001
    sync_id = 3'd7; data_fail = 1;
    push_rec(24'hF1F002, "R5 terminator");
    send_term(1, 3'b101);
    data_fail = 0;
    check(xfer_irq == 1, "R11 request after terminator", xfer_irq, 1);
    rd_ptr = 5'd15;

    // R4 no call open: codeword ignored; R5 term with no call ignored
    send_cw(32'hFFFF_FFFF, 3'b001, 0, 0, 0);
    send_term(0, 3'b000);
    check(xfer_irq == 0, "R4 idle codeword no effect", xfer_irq, 0);

    // R8 continuous mode: header-matching flag-0 codeword stored as message; wraps (R9)
    cont_mode = 1;
    push_rec(msg_rec(32'h7654_3210, 3'b011), "R8 R9 continuous wrap");
    send_cw(32'h7654_3210, 3'b011, 1, 3'd2, 2'b01);
    send_term(1, 3'b000);
    check(xfer_irq == 0, "R8 term ignored in continuous", xfer_irq, 0);
    @(negedge clk); sync_slot = 1; @(negedge clk); sync_slot = 0;
    @(negedge clk);
    check(xfer_irq == 1, "R11 sync slot request", xfer_irq, 1);
    rd_ptr = 5'd18;
    @(negedge clk); @(negedge clk);
    check(xfer_irq == 0, "R11 cleared after drain", xfer_irq, 0);
    @(negedge clk); sync_slot = 1; @(negedge clk); sync_slot = 0;
    @(negedge clk);
    check(xfer_irq == 0, "R11 sync slot empty no request", xfer_irq, 0);

    // R10 fill to full: 6 records into 16 bytes, tail of last dropped
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d = 32'h8000_0000 | (32'h0101_0101 * (i + 3));
      push_rec(msg_rec(d, 3'b000), "R10 fill");
      send_cw(d, 3'b000, 0, 0, 0);
    end
    check(xfer_irq == 1, "R10 R11 request on full", xfer_irq, 1);
    check(q.size() == 0, "R10 all expected bytes written", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule